// File: doc/BRIEF.md
# Indirect Register Port for a Sound Generator

This block is the processor-facing access path to the sixteen 8-bit control registers of a three-voice sound generator. It answers to two I/O addresses. The processor writes a register number to the index port; that number stays latched. Later data writes through the data port land in the latched register, and reads of the index port return that register's contents. Only the bus decode, the index latch and the register file are built here. The synthesis engines that use the registers are outside this block.

The block responds only when the I/O request line is high, address bit 7 is 0 and address bit 6 is 1. Address bit 0 chooses between the two ports. All state changes on the rising clock edge while the write strobe is high. Read data is combinational and is forced to zero whenever no decoded index read is under way. The first six registers also feed three tone period buses, one for each voice.

Top module: `sndreg_port`

## Requirements
- R1: With io_req low, or addr[7] high, or addr[6] low, a write changes neither the index latch nor any register, and rdata reads 0.
- R2: A decoded write with addr[0]=1 and wdata[7:4]=0 loads wdata[3:0] into the index latch at the next rising edge.
- R3: A decoded write with addr[0]=1 and wdata[7:4] nonzero leaves the index latch unchanged.
- R4: A decoded read (io_req=1, rd_en=1, addr[0]=1) drives rdata with the register named by the index latch, in the same cycle.
- R5: A decoded write with addr[0]=0 stores wdata into the register named by the index latch at the next rising edge, and no other register changes.
- R6: rdata is 0 whenever no decoded index read is active, and this includes a read with addr[0]=0.
- R7: A synchronous high rst clears the index latch and all sixteen registers to 0.
- R8: Voice k (k=0..2) has tone_period[12k+11:12k] = {register 2k+1 bits [3:0], register 2k}. Register 2k holds the fine byte and register 2k+1 holds the coarse nibble.
- R9: With wr_en low, no access changes the index latch or any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | I/O request qualifier |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | I/O address (bits 7, 6 and 0 decoded) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 outside a decoded index read |
| tone_period | output | 36 | Three 12-bit voice periods, voice 0 in the low bits |

## Verification
Reads are combinational. The bench therefore checks rdata 1 ns after it drives the inputs on the falling edge, inside the same low phase and before any edge. Writes of the index or a register take effect at the rising edge that follows. So tone_period and the model's view of the latch are checked 1 ns after that edge, and the effect of a latch write is checked through the next read or data write, never in the cycle of the write. Every stimulus is held for exactly one clock, so each result belongs to a known edge.

// File: rtl/sndreg_pkg.sv
package sndreg_pkg;

    typedef struct packed {
        logic idx_wr;   // decoded write to index port
        logic dat_wr;   // decoded write to data port
        logic idx_rd;   // decoded read of index port
    } bus_op_t;

    function automatic logic port_hit(input logic req, input logic a_hi, input logic a_lo);
        return req && !a_hi && a_lo;
    endfunction

endpackage

// File: rtl/sndreg_decode.sv
module sndreg_decode
    import sndreg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned HI_BIT  = 7,
    parameter int unsigned LO_BIT  = 6
) (
    input  logic              io_req,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output bus_op_t           op
);
    logic hit;
    logic unused_addr;

    assign hit         = port_hit(io_req, addr[HI_BIT], addr[LO_BIT]);
    assign unused_addr = ^addr;

    always_comb begin
        op.idx_wr = hit && wr_en && addr[0];
        op.dat_wr = hit && wr_en && !addr[0];
        op.idx_rd = hit && rd_en && addr[0];
    end
endmodule

// File: rtl/sndreg_file.sv
module sndreg_file
    import sndreg_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 16,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  bus_op_t                    op,
    input  logic [DATA_W-1:0]          wdata,
    output logic [IDX_W-1:0]           sel_q,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat,
    output logic [DATA_W-1:0]          rdata
);
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              idx_ok;

    assign idx_ok = (wdata[DATA_W-1:IDX_W] == '0);

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (op.idx_wr && idx_ok)
            sel_q <= wdata[IDX_W-1:0];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (op.dat_wr && (sel_q == IDX_W'(g)))
                regs[g] <= wdata;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    assign rdata = op.idx_rd ? regs[sel_q] : '0;
endmodule

// File: rtl/sndreg_tone_tap.sv
module sndreg_tone_tap #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned COARSE_W = 4,
    localparam int unsigned PER_W   = DATA_W + COARSE_W
) (
    input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
    output logic [NUM_CH*PER_W-1:0]    tone_period
);
    logic unused_regs;
    assign unused_regs = ^regs_flat;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign tone_period[c*PER_W +: PER_W] =
            {regs_flat[(2*c+1)*DATA_W +: COARSE_W], regs_flat[(2*c)*DATA_W +: DATA_W]};
    end
endmodule

// File: rtl/sndreg_port.sv
module sndreg_port
    import sndreg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned COARSE_W = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned PER_W   = DATA_W + COARSE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    io_req,
    input  logic                    rd_en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic [NUM_CH*PER_W-1:0] tone_period
);
    bus_op_t                    op;
    logic [IDX_W-1:0]           sel_q;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;

    sndreg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .io_req (io_req),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .addr   (addr),
        .op     (op)
    );

    sndreg_file #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_file (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wdata     (wdata),
        .sel_q     (sel_q),
        .regs_flat (regs_flat),
        .rdata     (rdata)
    );

    sndreg_tone_tap #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_CH(NUM_CH), .COARSE_W(COARSE_W)
    ) u_tap (
        .regs_flat   (regs_flat),
        .tone_period (tone_period)
    );
endmodule

// File: rtl/sndreg_port_chk.sv
module sndreg_port_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned TP_W   = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              io_req,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [IDX_W-1:0]  sel_q,
    input logic [TP_W-1:0]   tone_period
);
    logic hit;
    assign hit = io_req && !addr[7] && addr[6];

    // R1
    undecoded_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit) |=> ($stable(sel_q) && $stable(tone_period)));

    // R9
    no_strobe_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> ($stable(sel_q) && $stable(tone_period)));

    // R2
    index_load_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_en && addr[0] && wdata[DATA_W-1:IDX_W] == '0)
        |=> (sel_q == $past(wdata[IDX_W-1:0])));

    // R3
    index_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_en && addr[0] && wdata[DATA_W-1:IDX_W] != '0) |=> $stable(sel_q));

    // R5
    fine0_store_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_en && !addr[0] && sel_q == '0) |=> (tone_period[7:0] == $past(wdata)));

    // R6
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(hit && rd_en && addr[0]) |-> (rdata == '0));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sel_q == '0 && tone_period == '0));
endmodule

bind sndreg_port sndreg_port_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TP_W(NUM_CH*PER_W)
) u_chk (
    .clk(clk), .rst(rst), .io_req(io_req), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .sel_q(sel_q),
    .tone_period(tone_period)
);

// File: tb/sndreg_port_bench.sv
module sndreg_port_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        io_req, rd_en, wr_en;
    logic [7:0]  addr, wdata;
    logic [7:0]  rdata;
    logic [35:0] tone_period;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] m_reg [16];
    logic [3:0] m_sel;

    always #2.5 clk = ~clk;

    sndreg_port u_sndreg_port (
        .clk(clk), .rst(rst), .io_req(io_req), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .tone_period(tone_period)
    );

    function automatic logic [35:0] exp_tone();
        logic [35:0] t;
        for (int c = 0; c < 3; c++)
            t[c*12 +: 12] = {m_reg[2*c+1][3:0], m_reg[2*c]};
        return t;
    endfunction

    function automatic logic [7:0] mk_addr(input logic a0, input logic good);
        logic [7:0] a;
        a = 8'($urandom);
        a[0] = a0;
        if (good) begin
            a[7] = 1'b0; a[6] = 1'b1;
        end else if ($urandom_range(1, 0) == 0) begin
            a[7] = 1'b1;
        end else begin
            a[6] = 1'b0;
        end
        return a;
    endfunction

    task automatic check(input logic [35:0] act, input logic [35:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sel = '0;
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
    endtask

    // one bus cycle; rd checked in the low phase, writes checked after the edge
    task automatic bus(input logic req, input logic rd, input logic wr,
                       input logic [7:0] a, input logic [7:0] d, input string req_tag);
        logic hit;
        hit = req && !a[7] && a[6];
        @(negedge clk);
        io_req = req; rd_en = rd; wr_en = wr; addr = a; wdata = d;
        #1;
        if (hit && rd && a[0])
            check({28'd0, rdata}, {28'd0, m_reg[m_sel]}, {req_tag, "/R4"});
        else
            check({28'd0, rdata}, 36'd0, {req_tag, "/R6"});
        @(posedge clk);
        if (hit && wr) begin
            if (a[0] && d[7:4] == 4'd0) m_sel = d[3:0];
            else if (!a[0]) m_reg[m_sel] = d;
        end
        #1;
        check(tone_period, exp_tone(), {req_tag, "/R8"});
        io_req = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic sel_wr(input logic [7:0] d, input string t);
        bus(1'b1, 1'b0, 1'b1, mk_addr(1'b1, 1'b1), d, t);
    endtask
    task automatic dat_wr(input logic [7:0] d, input string t);
        bus(1'b1, 1'b0, 1'b1, mk_addr(1'b0, 1'b1), d, t);
    endtask
    task automatic idx_rd(input string t);
        bus(1'b1, 1'b1, 1'b0, mk_addr(1'b1, 1'b1), 8'h00, t);
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        io_req = 0; rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        model_reset();
        // R7: reset state
        #1 check(tone_period, 36'd0, "R7 tone");
        idx_rd("R7 read reg0");
        dat_wr(8'h5A, "R7 sel zero");
        idx_rd("R7 readback");

        // R2 / R5: fill voice registers, coarse upper nibble set
        for (int i = 0; i < 6; i++) begin
            sel_wr(8'(i), "R2");
            dat_wr(8'hF0 | 8'(i * 37), "R5");
            idx_rd("R4");
        end
        check(tone_period, exp_tone(), "R8 directed");

        // R3: rejected index
        sel_wr(8'h05, "R2");
        sel_wr(8'h13, "R3");
        dat_wr(8'h11, "R3 data to kept index");
        idx_rd("R3 readback");

        // R6: read of data port is zero
        bus(1'b1, 1'b1, 1'b0, mk_addr(1'b0, 1'b1), 8'h00, "R6 data port read");

        // R1: undecoded writes and reads
        bus(1'b0, 1'b0, 1'b1, mk_addr(1'b0, 1'b1), 8'hAA, "R1 no req");
        bus(1'b1, 1'b0, 1'b1, mk_addr(1'b0, 1'b0), 8'hBB, "R1 bad addr");
        bus(1'b1, 1'b0, 1'b1, mk_addr(1'b1, 1'b0), 8'h02, "R1 bad addr idx");
        bus(1'b1, 1'b1, 1'b0, mk_addr(1'b1, 1'b0), 8'h00, "R1 bad addr read");
        idx_rd("R1 readback");

        // R9: no strobe
        bus(1'b1, 1'b0, 1'b0, mk_addr(1'b0, 1'b1), 8'hCC, "R9");
        bus(1'b1, 1'b0, 1'b0, mk_addr(1'b1, 1'b1), 8'h01, "R9 idx");
        idx_rd("R9 readback");

        // random mix
        for (int k = 0; k < 600; k++) begin
            int unsigned kind;
            logic [7:0] d;
            kind = $urandom_range(5, 0);
            d = 8'($urandom);
            case (kind)
                0: sel_wr({4'd0, d[3:0]}, "R2 rand");
                1: sel_wr(d | 8'h10, "R3 rand");
                2: dat_wr(d, "R5 rand");
                3: idx_rd("R4 rand");
                4: bus(1'($urandom), 1'b0, 1'b1, mk_addr(1'($urandom), 1'b0), d, "R1 rand");
                default: bus(1'b1, 1'b0, 1'b0, mk_addr(1'($urandom), 1'b1), d, "R9 rand");
            endcase
        end

        // R7: reset mid-run
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        model_reset();
        #1 check(tone_period, 36'd0, "R7 rerun");
        idx_rd("R7 reread");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule